// File: doc/BRIEF.md
# Transmit Packet Framer

This block is the transmit-side packet engine of a sub-GHz radio's digital baseband. It turns bytes taken from an external transmit byte FIFO into a serial over-the-air bit stream. Each packet has the same parts in this order:

- a run of alternating-bit preamble bytes;
- a 16-bit sync word, or the same word sent twice;
- the payload;
- an optional CRC-16.

The payload and the CRC can be whitened with a pseudo-random sequence. Every byte is sent most significant bit first.

The packet length can be set in three ways. It can be a fixed count, it can be read from the first payload byte, or the packet can run on with no end. An 8-bit byte counter that wraps around is used for the count. This lets a packet longer than 255 bytes be sent: start it in the endless mode, then change the mode input to fixed while the packet is running. The packet then ends the next time the counter equals the programmed length.

The block has two streams, and both use valid/ready handshakes.

- **Byte input.** A FIFO byte is taken when `fifo_valid` and `fifo_ready` are both high at a clock edge. `fifo_ready` only rises at the edge where the last bit of the current byte is accepted.
- **Bit output.** A bit moves on when `bit_valid` and `bit_ready` are both high. While `bit_ready` is low, `bit_data` holds its value and nothing is lost.

If the FIFO is empty when a payload byte is needed, the framer stops in a sticky underflow state. A new `start` is the only way out of it.

Top module: `txf_framer`

## Requirements
- R1: After an accepted `start`, the bit stream begins with N bytes of 0xAA. N is decoded from `pre_code` as 0..7 -> {2,3,4,6,8,12,16,24}. If the FIFO is still empty when N bytes have gone, further 0xAA bytes follow until a byte is available.
- R2: After the preamble comes `sync_word[15:8]` and then `sync_word[7:0]`. When `sync_dual` is 1, these two bytes are sent a second time.
- R3: When `len_mode` is 0 (fixed), exactly `pkt_len` payload bytes are taken from the FIFO and sent. A `pkt_len` of 0 means 256 bytes, because the 8-bit counter wraps.
- R4: When `len_mode` is 1 (variable), the first payload byte L is sent as the length field. Exactly L more bytes follow it. L = 0 gives a packet with only the length byte.
- R5: When `len_mode` is 2 or 3 (endless), the packet does not end and the byte counter wraps modulo 256. If `len_mode` is changed to 0 during the packet, the packet ends with the byte that brings the counter (payload bytes sent) equal to `pkt_len`.
- R6: When `white_en` is 1, every byte after the sync word, CRC bytes included, is XORed with `s[7:0]` of a 9-bit register `s`.
  - `s` is set to 0x1FF at the start of the packet.
  - After each byte, `s` is advanced 8 steps. One step is `s = {s[0]^s[5], s[8:1]}`.
- R7: When `crc_en` is 1, two CRC bytes follow the payload, high byte first. The CRC:
  - uses polynomial 0x8005 with seed 0xFFFF, is not reflected, and has no final XOR;
  - is taken over the unwhitened bytes, including the length field;
  - is fed each byte MSB first into bits 15:8.
- R8: If a payload byte is needed while `fifo_valid` is 0, `underflow` goes to 1. `bit_valid`, `busy` and `fifo_ready` then stay 0, even if data arrives later. Only a new `start` clears this state.
- R9: While `bit_valid` is 1 and `bit_ready` is 0, `bit_data` holds its value. `fifo_ready` is only high in a cycle where a bit is being accepted.
- R10: After reset, `bit_valid`, `busy`, `underflow` and `fifo_ready` are all 0.
- R11: `start` has no effect while a packet is being sent (`busy` = 1). `busy` falls after the last bit has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a packet; acted on only when not busy |
| len_mode | input | 2 | 0 fixed, 1 variable, 2/3 endless |
| pkt_len | input | 8 | Programmed length for fixed mode |
| pre_code | input | 3 | Preamble length code |
| sync_dual | input | 1 | Send the sync word twice |
| sync_word | input | 16 | Sync word |
| white_en | input | 1 | Whitening enable |
| crc_en | input | 1 | CRC append enable |
| fifo_data | input | 8 | FIFO head byte |
| fifo_valid | input | 1 | FIFO not empty |
| fifo_ready | output | 1 | Pop the FIFO head byte |
| bit_data | output | 1 | Serial bit |
| bit_valid | output | 1 | Serial bit present |
| bit_ready | input | 1 | Downstream accepts the bit |
| busy | output | 1 | A packet is being sent |
| underflow | output | 1 | Sticky FIFO underflow state |

## Verification
Randomly sized fixed-length and variable-length packets are sent with random preamble codes, single or doubled sync words, and random whitening and CRC settings. The downstream `bit_ready` is random throughout, so each field boundary is checked while back-pressure is applied.

Several directed cases cover the boundaries:
- a zero-length variable packet and a fixed packet with `pkt_len` 0, which must send exactly 256 bytes and so shows the counter wrap;
- a 300-byte packet that starts in endless mode and is switched to fixed on the fly;
- a FIFO held empty at start, which must stretch the preamble;
- a FIFO that runs dry mid-packet, which must underflow and then ignore late data;
- a `start` pulse during a packet, which must change nothing.

// File: rtl/txf_pkg.sv
package txf_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_PRE, S_SYNC, S_DATA, S_CRC, S_UFLOW
  } state_e;

  localparam logic [1:0] LM_FIXED = 2'd0;
  localparam logic [1:0] LM_VAR   = 2'd1;

  localparam logic [7:0] PRE_BYTE = 8'hAA;

  // Preamble byte count decoded from a 3-bit code
  function automatic logic [4:0] pre_count(input logic [2:0] code);
    case (code)
      3'd0: return 5'd2;
      3'd1: return 5'd3;
      3'd2: return 5'd4;
      3'd3: return 5'd6;
      3'd4: return 5'd8;
      3'd5: return 5'd12;
      3'd6: return 5'd16;
      default: return 5'd24;
    endcase
  endfunction
endpackage

// File: rtl/txf_whiten.sv
module txf_whiten #(
  parameter int W   = 9,
  parameter int TAP = 5,
  parameter int OW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          seed,
  input  logic          step,
  output logic [OW-1:0] mask
);
  localparam logic [W-1:0] ONES = '1;

  logic [W-1:0] lfsr;

  function automatic logic [W-1:0] advance(input logic [W-1:0] s);
    logic [W-1:0] t;
    t = s;
    for (int i = 0; i < OW; i++) t = {t[0] ^ t[TAP], t[W-1:1]};
    return t;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    lfsr <= ONES;
    else if (seed) lfsr <= ONES;
    else if (step) lfsr <= advance(lfsr);
  end

  assign mask = lfsr[OW-1:0];

  // R6: a seeded register yields an all-ones first mask
  a_r6_seed_mask: assert property (@(posedge clk) disable iff (!rst_n)
    seed |=> mask == ONES[OW-1:0]);
endmodule

// File: rtl/txf_crc.sv
module txf_crc #(
  parameter int          W    = 16,
  parameter int          DW   = 8,
  parameter logic [15:0] POLY = 16'h8005,
  parameter logic [15:0] SEED = 16'hFFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic          upd,
  input  logic [DW-1:0] din,
  output logic [W-1:0]  crc
);
  localparam int PADW = W - DW;

  function automatic logic [W-1:0] feed(input logic [W-1:0] c, input logic [DW-1:0] d);
    logic [W-1:0] t;
    t = c ^ {d, {PADW{1'b0}}};
    for (int i = 0; i < DW; i++)
      t = t[W-1] ? ((t << 1) ^ POLY[W-1:0]) : (t << 1);
    return t;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc <= SEED[W-1:0];
    else if (init)  crc <= SEED[W-1:0];
    else if (upd)   crc <= feed(crc, din);
  end

  // R7: every packet's checksum starts from the seed
  a_r7_seed: assert property (@(posedge clk) disable iff (!rst_n)
    (init && !upd) |=> crc == SEED[W-1:0]);
endmodule

// File: rtl/txf_framer.sv
module txf_framer
  import txf_pkg::*;
#(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    len_mode,
  input  logic [BW-1:0] pkt_len,
  input  logic [2:0]    pre_code,
  input  logic          sync_dual,
  input  logic [15:0]   sync_word,
  input  logic          white_en,
  input  logic          crc_en,
  input  logic [BW-1:0] fifo_data,
  input  logic          fifo_valid,
  output logic          fifo_ready,
  output logic          bit_data,
  output logic          bit_valid,
  input  logic          bit_ready,
  output logic          busy,
  output logic          underflow
);
  localparam int CW = $clog2(BW);
  localparam logic [CW-1:0] LAST_BIT = CW'(BW - 1);

  state_e        st, st_n;
  logic [BW-1:0] sreg, ld_byte;
  logic [CW-1:0] bitn;
  logic [4:0]    pre_left;
  logic [1:0]    sidx, sidx_nx, sidx_last;
  logic [BW-1:0] cnt, cnt_n, vlen;
  logic          first_b, last_b, d_last, crc_lo;
  logic          ld, pop, go, fire, byte_end, len_byte;
  logic          wh_seed, wh_step;
  logic [BW-1:0] mask, wmask;
  logic [15:0]   crc;

  assign bit_valid = (st == S_PRE) || (st == S_SYNC) || (st == S_DATA) || (st == S_CRC);
  assign busy      = bit_valid;
  assign underflow = (st == S_UFLOW);
  assign bit_data  = sreg[BW-1];
  assign fifo_ready = pop;
  assign fire      = bit_valid && bit_ready;
  assign byte_end  = fire && (bitn == LAST_BIT);
  assign go        = start && !bit_valid;
  assign wmask     = white_en ? mask : '0;
  assign sidx_nx   = sidx + 2'd1;
  assign sidx_last = sync_dual ? 2'd3 : 2'd1;

  // Length bookkeeping for the byte now at the FIFO head
  always_comb begin
    len_byte = first_b && (len_mode == LM_VAR);
    cnt_n    = cnt + 1'b1;
    if (len_byte)                 d_last = (fifo_data == '0);
    else if (len_mode == LM_FIXED) d_last = (cnt_n == pkt_len);
    else if (len_mode == LM_VAR)   d_last = (cnt_n == vlen);
    else                           d_last = 1'b0;
  end

  always_comb begin
    st_n = st; ld = 1'b0; ld_byte = PRE_BYTE; pop = 1'b0;
    wh_seed = 1'b0; wh_step = 1'b0;
    case (st)
      S_IDLE, S_UFLOW: if (go) begin
        ld = 1'b1; st_n = S_PRE; wh_seed = 1'b1;
      end
      S_PRE: if (byte_end) begin
        ld = 1'b1;
        if (pre_left == '0 && fifo_valid) begin
          ld_byte = sync_word[15:8]; st_n = S_SYNC;
        end
      end
      S_SYNC: if (byte_end) begin
        if (sidx != sidx_last) begin
          ld = 1'b1;
          ld_byte = sidx_nx[0] ? sync_word[7:0] : sync_word[15:8];
        end else if (fifo_valid) begin
          ld = 1'b1; pop = 1'b1; wh_step = 1'b1;
          ld_byte = fifo_data ^ wmask; st_n = S_DATA;
        end else st_n = S_UFLOW;
      end
      S_DATA: if (byte_end) begin
        if (last_b) begin
          if (crc_en) begin
            ld = 1'b1; wh_step = 1'b1;
            ld_byte = crc[15:8] ^ wmask; st_n = S_CRC;
          end else st_n = S_IDLE;
        end else if (fifo_valid) begin
          ld = 1'b1; pop = 1'b1; wh_step = 1'b1;
          ld_byte = fifo_data ^ wmask;
        end else st_n = S_UFLOW;
      end
      S_CRC: if (byte_end) begin
        if (!crc_lo) begin
          ld = 1'b1; wh_step = 1'b1; ld_byte = crc[7:0] ^ wmask;
        end else st_n = S_IDLE;
      end
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sreg <= '0; bitn <= '0; pre_left <= '0; sidx <= '0;
      cnt <= '0; vlen <= '0; first_b <= 1'b0; last_b <= 1'b0; crc_lo <= 1'b0;
    end else begin
      st <= st_n;
      if (ld) begin
        sreg <= ld_byte; bitn <= '0;
      end else if (fire) begin
        sreg <= {sreg[BW-2:0], 1'b0}; bitn <= bitn + 1'b1;
      end
      if (go) begin
        pre_left <= pre_count(pre_code) - 5'd1;
        first_b <= 1'b1; cnt <= '0; last_b <= 1'b0;
      end else if (st == S_PRE && byte_end && pre_left != '0) begin
        pre_left <= pre_left - 5'd1;
      end
      if (st == S_PRE) sidx <= '0;
      else if (st == S_SYNC && byte_end) sidx <= sidx_nx;
      if (pop) begin
        first_b <= 1'b0; last_b <= d_last;
        if (len_byte) vlen <= fifo_data;
        else          cnt  <= cnt_n;
      end
      if (st == S_DATA) crc_lo <= 1'b0;
      else if (st == S_CRC && byte_end) crc_lo <= 1'b1;
    end
  end

  txf_whiten #(.W(9), .TAP(5), .OW(BW)) u_whiten (
    .clk(clk), .rst_n(rst_n), .seed(wh_seed), .step(wh_step), .mask(mask)
  );

  txf_crc #(.W(16), .DW(BW), .POLY(16'h8005), .SEED(16'hFFFF)) u_crc (
    .clk(clk), .rst_n(rst_n), .init(wh_seed), .upd(pop), .din(fifo_data), .crc(crc)
  );

  // R9: a stalled bit is held
  a_r9_hold_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid && !bit_ready) |=> (bit_valid && $stable(bit_data)));
  // R9: FIFO pops only on an accepted bit
  a_r9_pop_on_fire: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_ready |-> (bit_valid && bit_ready));
  // R8: underflow is sticky and silent until a new start
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (underflow && !start) |=> (underflow && !bit_valid));
  a_r8_no_pop: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |-> !fifo_ready);
  // R1: every packet opens with the leading one of the preamble pattern
  a_r1_first_bit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> bit_data);
endmodule

// File: tb/txf_framer_bench.sv
`timescale 1ns/1ps
module txf_framer_bench;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] len_mode = 2'd0;
  logic [7:0] pkt_len = 8'd0;
  logic [2:0] pre_code = 3'd0;
  logic sync_dual = 1'b0, white_en = 1'b0, crc_en = 1'b0;
  logic [15:0] sync_word = 16'hD391;
  logic [7:0] fifo_data = 8'h00;
  logic fifo_valid = 1'b0, bit_ready = 1'b0;
  logic fifo_ready, bit_data, bit_valid, busy, underflow;

  txf_framer u_txf_framer (
    .clk(clk), .rst_n(rst_n), .start(start), .len_mode(len_mode), .pkt_len(pkt_len),
    .pre_code(pre_code), .sync_dual(sync_dual), .sync_word(sync_word),
    .white_en(white_en), .crc_en(crc_en), .fifo_data(fifo_data), .fifo_valid(fifo_valid),
    .fifo_ready(fifo_ready), .bit_data(bit_data), .bit_valid(bit_valid),
    .bit_ready(bit_ready), .busy(busy), .underflow(underflow)
  );

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  logic [7:0] fifo_q[$], pay_q[$], exp_q[$], rx_q[$];
  logic [7:0] cur = 8'h00;
  int nbits = 0, pops = 0, pops_base = 0, sw_at = 0, rdy_pct = 70;
  logic [1:0] cfg_mode = 2'd0;
  bit sw_armed = 1'b0, fifo_open = 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nfail++;
      $display("FAIL R11 watchdog act=%0d exp=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  // Stimulus at the falling edge, handshakes observed once settled
  always @(negedge clk) begin
    bit_ready  = ($urandom_range(99) < rdy_pct);
    fifo_valid = fifo_open && (fifo_q.size() > 0);
    fifo_data  = fifo_valid ? fifo_q[0] : 8'h00;
    len_mode   = (sw_armed && (pops - pops_base) >= sw_at) ? 2'd0 : cfg_mode;
    #1;
    if (bit_valid && bit_ready) begin
      cur = {cur[6:0], bit_data};
      nbits++;
      if (nbits == 8) begin rx_q.push_back(cur); nbits = 0; end
    end
    if (fifo_valid && fifo_ready) begin
      void'(fifo_q.pop_front());
      pops++;
    end
  end

  function automatic int pre_n(input logic [2:0] c);
    int t[8] = '{2, 3, 4, 6, 8, 12, 16, 24};
    return t[c];
  endfunction

  function automatic logic [8:0] pn9_adv(input logic [8:0] s);
    logic [8:0] t = s;
    for (int i = 0; i < 8; i++) t = {t[0] ^ t[5], t[8:1]};
    return t;
  endfunction

  function automatic logic [15:0] crc_feed(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] t = c ^ {d, 8'h00};
    for (int i = 0; i < 8; i++) t = t[15] ? ((t << 1) ^ 16'h8005) : (t << 1);
    return t;
  endfunction

  // Expected stream from pay_q and current configuration
  task automatic build_exp();
    logic [15:0] c = 16'hFFFF;
    logic [8:0] s = 9'h1FF;
    logic [7:0] body[$];
    exp_q.delete();
    for (int i = 0; i < pre_n(pre_code); i++) exp_q.push_back(8'hAA);
    for (int k = 0; k < (sync_dual ? 2 : 1); k++) begin
      exp_q.push_back(sync_word[15:8]);
      exp_q.push_back(sync_word[7:0]);
    end
    foreach (pay_q[i]) begin body.push_back(pay_q[i]); c = crc_feed(c, pay_q[i]); end
    if (crc_en) begin body.push_back(c[15:8]); body.push_back(c[7:0]); end
    foreach (body[i]) begin
      exp_q.push_back(white_en ? (body[i] ^ s[7:0]) : body[i]);
      s = pn9_adv(s);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); #2 start = 1'b1;
    @(negedge clk); #2 start = 1'b0;
  endtask

  task automatic run_pkt(input string tag, input bit exact_pre, input int open_after,
                         input bit poke);
    int k = 0, bad = 0, np, nsync, lim = 0;
    build_exp();
    rx_q.delete(); nbits = 0; pops_base = pops;
    foreach (pay_q[i]) fifo_q.push_back(pay_q[i]);
    fifo_open = (open_after == 0);
    pulse_start();
    while (busy && lim < 20000) begin
      @(negedge clk); #2;
      lim++;
      start = poke && (lim == 40);
      if (lim == open_after) fifo_open = 1'b1;
    end
    start = 1'b0; sw_armed = 1'b0; fifo_open = 1'b1;
    chk(lim < 20000, {tag, " timeout"}, lim, 20000);
    np = pre_n(pre_code);
    while (k < rx_q.size() && rx_q[k] == 8'hAA) k++;
    chk(exact_pre ? (k == np) : (k > np), "R1 preamble count", k, np);
    nsync = sync_dual ? 4 : 2;
    for (int i = 0; i < nsync; i++)
      if (k + i >= rx_q.size() || rx_q[k + i] != exp_q[np + i]) bad++;
    chk(bad == 0, "R2 sync bytes", bad, 0);
    bad = 0;
    for (int i = np + nsync; i < exp_q.size(); i++)
      if (k + i - np >= rx_q.size() || rx_q[k + i - np] != exp_q[i]) bad++;
    chk(bad == 0, {tag, " body bytes"}, bad, 0);
    chk(rx_q.size() - k == exp_q.size() - np && nbits == 0, {tag, " length"},
        rx_q.size() - k, exp_q.size() - np);
    chk(fifo_q.size() == 0 && !busy, {tag, " R11 FIFO drained, idle"}, fifo_q.size(), 0);
  endtask

  task automatic make_pay(input int mode, input int n);
    pay_q.delete();
    if (mode == 1) pay_q.push_back(8'(n));
    for (int i = 0; i < n; i++) pay_q.push_back(8'($urandom_range(255)));
  endtask

  task automatic set_cfg(input int mode, input int plen, input int pc, input bit dual,
                         input bit wh, input bit cr);
    cfg_mode = 2'(mode); pkt_len = 8'(plen); pre_code = 3'(pc);
    sync_dual = dual; white_en = wh; crc_en = cr;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk(!bit_valid && !busy && !underflow && !fifo_ready, "R10 reset state",
        {bit_valid, busy, underflow, fifo_ready}, 0);

    // Random fixed and variable packets under random back-pressure
    for (int p = 0; p < 20; p++) begin
      int mode = $urandom_range(1);
      int n = (mode == 0) ? $urandom_range(24, 1) : $urandom_range(24);
      sync_word = 16'($urandom_range(16'hFFFF));
      if (sync_word[15:8] == 8'hAA) sync_word[15:8] = 8'hD3;
      set_cfg(mode, n, $urandom_range(7), $urandom_range(1), $urandom_range(1),
              $urandom_range(1));
      make_pay(mode, n);
      run_pkt(mode == 0 ? "R3 R6 R7 fixed" : "R4 R6 R7 variable", 1'b1, 0, 1'b0);
    end
    sync_word = 16'hD391;

    // Variable with zero length field
    set_cfg(1, 0, 0, 0, 1, 1); make_pay(1, 0);
    run_pkt("R4 zero length", 1'b1, 0, 1'b0);

    // Fixed with programmed length 0: counter wraps, 256 bytes
    set_cfg(0, 0, 2, 0, 1, 1); make_pay(0, 256);
    run_pkt("R3 wrap 256", 1'b1, 0, 1'b0);

    // Endless start, switched to fixed on the fly: 300 bytes
    set_cfg(2, 300 % 256, 1, 1, 1, 1); make_pay(0, 300);
    sw_at = 100; sw_armed = 1'b1;
    run_pkt("R5 endless to fixed", 1'b1, 0, 1'b0);

    // Empty FIFO at start stretches the preamble
    set_cfg(0, 6, 0, 0, 0, 1); make_pay(0, 6);
    run_pkt("R1 stretched preamble", 1'b0, 60, 1'b0);

    // Start pulse during a packet changes nothing
    set_cfg(0, 12, 3, 0, 1, 0); make_pay(0, 12);
    run_pkt("R11 start ignored", 1'b1, 0, 1'b1);

    // Underflow: fixed length 10 with only 5 bytes present
    begin
      int lim = 0;
      set_cfg(0, 10, 0, 0, 0, 0); make_pay(0, 5);
      rx_q.delete(); nbits = 0;
      foreach (pay_q[i]) fifo_q.push_back(pay_q[i]);
      pulse_start();
      while (!underflow && lim < 5000) begin @(negedge clk); #2; lim++; end
      chk(underflow && !bit_valid && !busy, "R8 underflow entered",
          {underflow, bit_valid, busy}, 3'b100);
      chk(rx_q.size() == 2 + 2 + 5, "R8 bytes before underflow", rx_q.size(), 9);
      for (int i = 0; i < 4; i++) fifo_q.push_back(8'h5A);
      repeat (50) @(negedge clk);
      #2;
      chk(fifo_q.size() == 4 && !bit_valid && underflow, "R8 late data ignored",
          fifo_q.size(), 4);
      fifo_q.delete();
    end

    // A new start leaves underflow and sends a whole packet
    set_cfg(1, 3, 4, 1, 0, 1); make_pay(1, 3);
    run_pkt("R8 restart after underflow", 1'b1, 0, 1'b0);
    chk(!underflow, "R8 underflow cleared", underflow, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule